// File: doc/BRIEF.md
# Burst Address Counter with Readback

This block is the address counter for one port of a dual-ported memory. It spans the whole array depth. On every rising clock edge, active-low controls make it clear, take an external address, step forward by one or stay put. The registered count is the memory address that the port uses. When stepping past the last location, the count returns to zero.

The block can also show its count on the port's data lines. This happens when the counter is in its hold state while a read is requested with the output enable low. Where the bits land depends on the port width currently in use (36, 18 or 9 lines):

- **36-line port:** the count starts at line 3.
- **18-line port:** the count starts at line 3, and the word sub-address bit is added on line 2.
- **9-line port:** the value is split over two cycles. The upper count bits come first. The lower count bits follow, together with the word and byte sub-address bits.

A per-line enable bus marks which lines the port drives.

Readback is a plain bus qualified by its enables, with no back-pressure. The data is valid in every cycle that the enables are non-zero. In the 9-line case the consumer must take one beat per clock. The sub-address bits come in from the port's width adapter.

Top module: `burst_addr_ctr`

## Requirements
- R1: When `cnt_rst_n` is low at a rising edge, `mem_addr` becomes 0 whatever the other controls are. While it is low, no readback is driven.
- R2: With `cnt_rst_n` high and both `adr_stb_n` and `cnt_en_n` low at an edge, `mem_addr` takes `ext_addr`.
- R3: With `adr_stb_n` high and `cnt_en_n` low, `mem_addr` increases by one per edge. It wraps from 2^ADDR_W-1 to 0.
- R4: With `adr_stb_n` and `cnt_en_n` both high, `mem_addr` holds and `ext_addr` has no effect.
- R5: With `adr_stb_n` low and `cnt_en_n` high, `mem_addr` holds and `ext_addr` is not loaded.
- R6: Readback is active when all of these hold: `cnt_rst_n` high, `adr_stb_n` high, `cnt_en_n` high, `is_read` high and `oe_n` low. Otherwise `rb_oe` and `rb_data` are all zero.
- R7: When `width_sel` is 0 (36 lines), readback places count bit i on line 3+i, and every other line is 0. All 36 enables are set.
- R8: When `width_sel` is 1 (18 lines), the count is on lines 3 upward and `sub_word` is on line 2. Lines 0 and 1 are 0, and enables 0 to 17 are set.
- R9: When `width_sel` is 2 or 3 (9 lines), the first phase places count bits 6 and up on lines 0 upward. The second phase places count bits 0 to 5 on lines 3 to 8, `sub_word` on line 2 and `sub_byte` on line 1. Line 0 is 0, and only enables 0 to 8 are set.
- R10: In 9-line readback, the phase alternates first, second, first and so on, advancing on each edge at which readback is active. It restarts at the first phase after any cycle without active readback.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Port clock, rising edge |
| cnt_rst_n | input | 1 | Synchronous counter clear, active low, highest priority |
| adr_stb_n | input | 1 | Address strobe, active low |
| cnt_en_n | input | 1 | Count enable, active low |
| ext_addr | input | ADDR_W | External address for loading |
| is_read | input | 1 | High for a read access |
| oe_n | input | 1 | Output enable, active low |
| width_sel | input | 2 | Port width: 0 = 36, 1 = 18, 2 or 3 = 9 lines |
| sub_word | input | 1 | Word sub-address bit from the width adapter |
| sub_byte | input | 1 | Byte sub-address bit from the width adapter |
| mem_addr | output | ADDR_W | Registered counter value, the array address |
| rb_data | output | 36 | Readback data lines |
| rb_oe | output | 36 | Per-line output enables for readback |

## Verification
The counter is tried with patterns that each isolate one behaviour:

- **Full sweep:** an increment run across the entire array depth separates correct wrap from early or late rollover.
- **Spread loads:** loads of values spread across the range, including all ones, expose dropped or swapped address bits.
- **Hold with a moving external address:** holds in both strobe states while `ext_addr` keeps changing show that a hold is never mistaken for a load.
- **Readback patterns:** readback runs over many count values, with every sub-address combination and at each width. They separate correct bit placement from shifts by one line. Long 9-line readouts, interrupted and resumed, show whether the phase alternates and restarts.

// File: rtl/bac_pkg.sv
`timescale 1ns/1ps
package bac_pkg;
  typedef enum logic [1:0] {
    WID_36  = 2'd0,
    WID_18  = 2'd1,
    WID_9   = 2'd2,
    WID_9B  = 2'd3
  } width_e;
endpackage

// File: rtl/bac_counter.sv
`timescale 1ns/1ps
module bac_counter #(
  parameter int ADDR_W = 15
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              stb_n,
  input  logic              en_n,
  input  logic [ADDR_W-1:0] ext_addr,
  output logic [ADDR_W-1:0] count
);
  always_ff @(posedge clk) begin
    if (!rst_n)
      count <= '0;
    else if (!en_n && !stb_n)
      count <= ext_addr;
    else if (!en_n && stb_n)
      count <= count + ADDR_W'(1);
  end
endmodule

// File: rtl/bac_phase.sv
`timescale 1ns/1ps
module bac_phase (
  input  logic clk,
  input  logic rst_n,
  input  logic active,
  output logic second
);
  always_ff @(posedge clk) begin
    if (!rst_n)
      second <= 1'b0;
    else if (active)
      second <= ~second;
    else
      second <= 1'b0;
  end
endmodule

// File: rtl/bac_rb_map.sv
`timescale 1ns/1ps
module bac_rb_map #(
  parameter int ADDR_W = 15,
  parameter int LANE_W = 9,
  parameter int LANES  = 4
) (
  input  logic                       drive,
  input  bac_pkg::width_e            width,
  input  logic                       second,
  input  logic [ADDR_W-1:0]          count,
  input  logic                       sub_word,
  input  logic                       sub_byte,
  output logic [LANE_W*LANES-1:0]    data,
  output logic [LANE_W*LANES-1:0]    oe
);
  localparam int DATA_W   = LANE_W * LANES;
  localparam int HALF_W   = DATA_W / 2;
  localparam int CNT_OFS  = 3;
  localparam int WORD_POS = 2;
  localparam int BYTE_POS = 1;
  localparam int LO_W     = LANE_W - CNT_OFS;
  localparam int HI_W     = ADDR_W - LO_W;

  always_comb begin
    data = '0;
    oe   = '0;
    if (drive) begin
      unique case (width)
        bac_pkg::WID_36: begin
          data[CNT_OFS +: ADDR_W] = count;
          oe = '1;
        end
        bac_pkg::WID_18: begin
          data[CNT_OFS +: ADDR_W] = count;
          data[WORD_POS]          = sub_word;
          oe[HALF_W-1:0]          = '1;
        end
        default: begin
          if (!second) begin
            data[HI_W-1:0] = count[ADDR_W-1:LO_W];
          end else begin
            data[CNT_OFS +: LO_W] = count[LO_W-1:0];
            data[WORD_POS]        = sub_word;
            data[BYTE_POS]        = sub_byte;
          end
          oe[LANE_W-1:0] = '1;
        end
      endcase
    end
  end
endmodule

// File: rtl/burst_addr_ctr.sv
`timescale 1ns/1ps
module burst_addr_ctr #(
  parameter int ADDR_W = 15,
  parameter int LANE_W = 9,
  parameter int LANES  = 4
) (
  input  logic                    clk,
  input  logic                    cnt_rst_n,
  input  logic                    adr_stb_n,
  input  logic                    cnt_en_n,
  input  logic [ADDR_W-1:0]       ext_addr,
  input  logic                    is_read,
  input  logic                    oe_n,
  input  logic [1:0]              width_sel,
  input  logic                    sub_word,
  input  logic                    sub_byte,
  output logic [ADDR_W-1:0]       mem_addr,
  output logic [LANE_W*LANES-1:0] rb_data,
  output logic [LANE_W*LANES-1:0] rb_oe
);
  bac_pkg::width_e width;
  logic            readout;
  logic            narrow;
  logic            second;

  assign width   = bac_pkg::width_e'(width_sel);
  assign readout = cnt_rst_n & adr_stb_n & cnt_en_n & is_read & ~oe_n;
  assign narrow  = (width == bac_pkg::WID_9) || (width == bac_pkg::WID_9B);

  bac_counter #(.ADDR_W(ADDR_W)) u_cnt (
    .clk      (clk),
    .rst_n    (cnt_rst_n),
    .stb_n    (adr_stb_n),
    .en_n     (cnt_en_n),
    .ext_addr (ext_addr),
    .count    (mem_addr)
  );

  bac_phase u_phase (
    .clk    (clk),
    .rst_n  (cnt_rst_n),
    .active (readout & narrow),
    .second (second)
  );

  bac_rb_map #(.ADDR_W(ADDR_W), .LANE_W(LANE_W), .LANES(LANES)) u_map (
    .drive    (readout),
    .width    (width),
    .second   (second),
    .count    (mem_addr),
    .sub_word (sub_word),
    .sub_byte (sub_byte),
    .data     (rb_data),
    .oe       (rb_oe)
  );
endmodule

// File: rtl/burst_addr_ctr_chk.sv
`timescale 1ns/1ps
module burst_addr_ctr_chk #(
  parameter int ADDR_W = 15,
  parameter int LANE_W = 9,
  parameter int LANES  = 4
) (
  input logic                    clk,
  input logic                    cnt_rst_n,
  input logic                    adr_stb_n,
  input logic                    cnt_en_n,
  input logic [ADDR_W-1:0]       ext_addr,
  input logic                    is_read,
  input logic                    oe_n,
  input logic [1:0]              width_sel,
  input logic                    sub_word,
  input logic                    sub_byte,
  input logic [ADDR_W-1:0]       mem_addr,
  input logic [LANE_W*LANES-1:0] rb_data,
  input logic [LANE_W*LANES-1:0] rb_oe
);
  localparam int LO_W = LANE_W - 3;
  localparam int HI_W = ADDR_W - LO_W;

  logic armed = 1'b0;
  logic rd_cond;
  always_ff @(posedge clk) armed <= 1'b1;
  assign rd_cond = cnt_rst_n && adr_stb_n && cnt_en_n && is_read && !oe_n;

  // R1
  rst_clear_chk: assert property (@(posedge clk)
    armed && !$past(cnt_rst_n) |-> mem_addr == '0);

  // R2
  load_take_chk: assert property (@(posedge clk) disable iff (!cnt_rst_n)
    armed && $past(cnt_rst_n) && !$past(adr_stb_n) && !$past(cnt_en_n)
    |-> mem_addr == $past(ext_addr));

  // R3
  step_wrap_chk: assert property (@(posedge clk) disable iff (!cnt_rst_n)
    armed && $past(cnt_rst_n) && $past(adr_stb_n) && !$past(cnt_en_n)
    |-> mem_addr == ADDR_W'($past(mem_addr) + 1'b1));

  // R4 R5
  hold_still_chk: assert property (@(posedge clk) disable iff (!cnt_rst_n)
    armed && $past(cnt_rst_n) && $past(cnt_en_n) |-> $stable(mem_addr));

  // R6
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!cnt_rst_n)
    !rd_cond |-> (rb_oe == '0 && rb_data == '0));

  // R9
  narrow_lanes_chk: assert property (@(posedge clk) disable iff (!cnt_rst_n)
    rd_cond && width_sel[1]
    |-> ($countones(rb_oe) == LANE_W && rb_oe[LANE_W-1:0] == '1));

  // R10
  phase_restart_chk: assert property (@(posedge clk) disable iff (!cnt_rst_n)
    armed && rd_cond && width_sel[1] && !$past(rd_cond)
    |-> rb_data[HI_W-1:0] == mem_addr[ADDR_W-1:LO_W]);
endmodule

bind burst_addr_ctr burst_addr_ctr_chk #(
  .ADDR_W(ADDR_W), .LANE_W(LANE_W), .LANES(LANES)
) u_chk (.*);

// File: tb/sim_burst_addr_ctr.sv
`timescale 1ns/1ps
module sim_burst_addr_ctr;
  localparam int AW    = 15;
  localparam int DEPTH = 1 << AW;

  logic          clk = 1'b0;
  logic          cnt_rst_n, adr_stb_n, cnt_en_n, is_read, oe_n, sub_word, sub_byte;
  logic [AW-1:0] ext_addr;
  logic [1:0]    width_sel;
  logic [AW-1:0] mem_addr;
  logic [35:0]   rb_data, rb_oe;

  int n_cmp = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  burst_addr_ctr u0 (
    .clk(clk), .cnt_rst_n(cnt_rst_n), .adr_stb_n(adr_stb_n), .cnt_en_n(cnt_en_n),
    .ext_addr(ext_addr), .is_read(is_read), .oe_n(oe_n), .width_sel(width_sel),
    .sub_word(sub_word), .sub_byte(sub_byte), .mem_addr(mem_addr),
    .rb_data(rb_data), .rb_oe(rb_oe)
  );

  task automatic chk(input string rq, input logic [63:0] got, input logic [63:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", rq, got, exp);
    end
  endtask

  task automatic edge_wait();
    @(posedge clk);
    #1;
  endtask

  task automatic ctl(input logic r, input logic s, input logic e, input int a);
    cnt_rst_n = r; adr_stb_n = s; cnt_en_n = e; ext_addr = AW'(a);
  endtask

  function automatic logic [63:0] exp_data(input int mode, input int cnt,
                                           input int w, input int b, input int ph);
    if (mode == 0) return 64'(cnt) << 3;
    if (mode == 1) return (64'(cnt) << 3) | (64'(w) << 2);
    if (ph == 0)   return 64'(cnt) >> 6;
    return (64'(cnt % 64) << 3) | (64'(w) << 2) | (64'(b) << 1);
  endfunction

  function automatic logic [63:0] exp_oe(input int mode);
    if (mode == 0) return (64'd1 << 36) - 1;
    if (mode == 1) return (64'd1 << 18) - 1;
    return 64'd511;
  endfunction

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog actual=running expected=finished");
    summary();
    $finish;
  end

  initial begin
    ctl(0, 1, 1, 0);
    is_read = 0; oe_n = 1; width_sel = 0; sub_word = 0; sub_byte = 0;
    edge_wait(); edge_wait();
    chk("R1 reset state", 64'(mem_addr), 0);
    chk("R6 reset no readback", 64'(rb_oe), 0);

    // R2 load, then R1 priority over load and increment
    ctl(1, 0, 0, 'h1234); edge_wait();
    chk("R2 load", 64'(mem_addr), 'h1234);
    ctl(0, 0, 0, 'h777); edge_wait();
    chk("R1 clear beats load", 64'(mem_addr), 0);
    ctl(1, 0, 0, 'h55); edge_wait();
    ctl(0, 1, 0, 0); edge_wait();
    chk("R1 clear beats increment", 64'(mem_addr), 0);
    ctl(0, 1, 1, 0); is_read = 1; oe_n = 0; #1;
    chk("R1 R6 no readback in clear", 64'(rb_oe), 0);
    edge_wait();

    // R2 spread loads
    is_read = 0; oe_n = 1;
    for (int i = 0; i < 64; i++) begin
      int a;
      a = (i == 63) ? DEPTH - 1 : (i * 1237 + 5) % DEPTH;
      ctl(1, 0, 0, a); edge_wait();
      chk("R2 load value", 64'(mem_addr), 64'(a));
    end

    // R3 full sweep with wrap
    ctl(1, 0, 0, 0); edge_wait();
    ctl(1, 1, 0, 'h3C3C);
    for (int k = 1; k <= DEPTH; k++) begin
      edge_wait();
      chk("R3 increment", 64'(mem_addr), 64'(k % DEPTH));
    end
    ctl(1, 0, 0, DEPTH - 1); edge_wait();
    ctl(1, 1, 0, 0); edge_wait();
    chk("R3 wrap to zero", 64'(mem_addr), 0);

    // R4 hold, external address moving
    ctl(1, 0, 0, 'h2AB); edge_wait();
    for (int k = 0; k < 8; k++) begin
      ctl(1, 1, 1, k * 911); is_read = k[0]; oe_n = ~k[0] ? 1'b0 : 1'b1;
      edge_wait();
      chk("R4 hold", 64'(mem_addr), 'h2AB);
      chk("R6 no readback without both read and enable", 64'(rb_oe), 0);
    end

    // R5 strobe low, enable high holds
    is_read = 1; oe_n = 0;
    for (int k = 0; k < 8; k++) begin
      ctl(1, 0, 1, k * 3001 + 1); edge_wait();
      chk("R5 no load", 64'(mem_addr), 'h2AB);
      chk("R6 no readback with strobe low", 64'(rb_data) | 64'(rb_oe), 0);
    end

    // R7 R8 R9 R10 readback sweep
    for (int v = 0; v < 256; v++) begin
      int val;
      val = (v == 255) ? DEPTH - 1 : (v * 129 + 3) % DEPTH;
      for (int m = 0; m < 4; m++) begin
        int mode;
        mode = (m > 2) ? 2 : m;
        ctl(1, 0, 0, val); is_read = 0; oe_n = 1; edge_wait();
        ctl(1, 1, 1, ~val); is_read = 1; oe_n = 0;
        width_sel = 2'(m); sub_word = v[0]; sub_byte = v[1];
        if (mode < 2) begin
          #1;
          chk(mode == 0 ? "R7 x36 data" : "R8 x18 data", 64'(rb_data),
              exp_data(mode, val, v[0], v[1], 0));
          chk(mode == 0 ? "R7 x36 enables" : "R8 x18 enables", 64'(rb_oe), exp_oe(mode));
          edge_wait();
          chk("R4 hold during readback", 64'(mem_addr), 64'(val));
        end else begin
          for (int ph = 0; ph < 4; ph++) begin
            #1;
            chk("R9 R10 x9 phase data", 64'(rb_data), exp_data(2, val, v[0], v[1], ph % 2));
            chk("R9 x9 enables", 64'(rb_oe), exp_oe(2));
            edge_wait();
          end
          oe_n = 1; #1;
          chk("R6 enable dropped", 64'(rb_data) | 64'(rb_oe), 0);
          edge_wait();
          oe_n = 0; #1;
          chk("R10 restart first phase", 64'(rb_data), exp_data(2, val, v[0], v[1], 0));
          edge_wait();
          #1;
          chk("R10 second after restart", 64'(rb_data), exp_data(2, val, v[0], v[1], 1));
          edge_wait();
        end
      end
    end

    summary();
    $finish;
  end
endmodule